// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This core executes a byte-coded program in which arithmetic names no operands. Every operation reads its sources from the top of an expression stack and leaves its result there. The four topmost stack entries live in registers. Deeper entries move to a spill region inside the data memory, so most instructions cause no stack traffic on the memory port. The same single-ported data memory also holds program variables. Variables enter the stack through a load instruction and leave it through a store instruction. Constants come from the instruction itself.

A one-cycle `start` pulse, given while the core is idle or halted, clears the stack and the flags and begins execution at byte 0. The core runs until it reaches a halt opcode or a stack fault, and then holds `done` high. Two debug outputs show the cached top entry and the total stack depth.

The control FSM has three states. In `ST_IDLE` (after reset), `start` leads to `ST_RUN`. `ST_RUN` stays in `ST_RUN` while instructions execute or a stack transfer stalls. `ST_RUN` goes to `ST_HALT` on a halt opcode, on underflow or on overflow. In `ST_HALT`, `start` leads back to `ST_RUN`. Inside `ST_RUN`, each cycle takes exactly one action:
- `ACT_EXEC` runs the instruction and advances the PC.
- `ACT_SPILL` writes the deepest register to memory.
- `ACT_FILL` reloads one entry from memory.
- `ACT_STOP` handles a halt or an illegal opcode.
- `ACT_UNDER` handles a missing operand.
- `ACT_OVER` handles a full spill region.

Top module: `stk_core`

## Requirements
- R1: After reset, and between runs, `busy`, `dmem_re` and `dmem_we` are low. A `start` pulse in idle or halted state clears the depth and both flags and begins at byte 0. `busy` is high for every running cycle. `done` is high once the core stops.
- R2: Opcode encoding: 0x00 halts, 0x01 loads a variable, 0x02 loads a literal, 0x03 stores to a variable, 0x10 adds, 0x11 multiplies. Any other opcode halts with both flags low. The three-byte instructions (0x01, 0x02, 0x03) carry a 16-bit field whose high byte is at PC+1 and whose low byte is at PC+2. The PC advances by 3 for these and by 1 for add and multiply. Data addresses use the low DA_W bits of the field.
- R3: Opcode 0x01 places `dmem[field]` on the top of the stack. Opcode 0x02 places the field value itself on the top, and `dmem_re` stays low during it.
- R4: Opcode 0x03 writes the top entry to `dmem[field]` and removes it from the stack.
- R5: Add and multiply replace the top two entries with one entry: their sum, or the low 16 bits of their product.
- R6: Four entries are cached. A push that finds all four full first spends one extra cycle writing the deepest cached entry to address SPILL_BASE+k, where k is the number of entries already spilled.
- R7: An operation that needs more cached entries than are present spends one extra cycle per entry. Each such cycle reloads one entry from the highest occupied spill slot, and the reloaded entry goes beneath the cached ones.
- R8: An operation that needs more entries than the whole stack holds sets the sticky underflow flag and halts. The stack stays unchanged and no memory write occurs.
- R9: A push that finds four cached entries and SPILL_DEPTH spilled entries sets the overflow flag and halts. Nothing is written.
- R10: `depth_dbg` gives the total stack depth. `tos_dbg` gives the top cached entry whenever at least one entry is cached.
- R11: The program "load a, literal 145, load b, add, multiply, store res, halt" leaves a*(145+b) (mod 2^16) in res and takes 7 running cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run from byte 0 (idle or halted only) |
| busy | output | 1 | Core is executing |
| done | output | 1 | Core has stopped |
| imem_addr | output | IA_W | Byte address of the current instruction |
| imem_rdata | input | 24 | Bytes at addr (7:0), addr+1 (15:8), addr+2 (23:16) |
| dmem_addr | output | DA_W | Data memory address |
| dmem_re | output | 1 | Data read this cycle |
| dmem_we | output | 1 | Data write this cycle |
| dmem_wdata | output | 16 | Write data |
| dmem_rdata | input | 16 | Combinational read data |
| tos_dbg | output | 16 | Top cached stack entry |
| depth_dbg | output | DEP_W | Total stack depth |
| ovf_flag | output | 1 | Spill region overflow (sticky per run) |
| unf_flag | output | 1 | Stack underflow (sticky per run) |

## Verification
The bench sweeps the stack depth from one to twelve entries, both by filling the stack and by filling and then draining it. It checks every stored value, every spill slot and the exact running-cycle count. A core that spilled the wrong entry or reloaded from the wrong slot would return the values in the wrong order. A core that stalled a different number of cycles per transfer would miss the cycle budget. Arithmetic chains that need reloads in the middle of the chain check that a reloaded entry lands beneath the cached ones. Separate runs push one entry past capacity and pop or add on a short stack; a core that wrote memory before halting would corrupt a preset sentinel word.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam logic [7:0] OPC_HALT = 8'h00;
    localparam logic [7:0] OPC_LOAD = 8'h01;
    localparam logic [7:0] OPC_LIT  = 8'h02;
    localparam logic [7:0] OPC_STORE = 8'h03;
    localparam logic [7:0] OPC_ADD  = 8'h10;
    localparam logic [7:0] OPC_MUL  = 8'h11;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HALT} state_t;

    typedef enum logic [2:0] {
        ACT_EXEC, ACT_SPILL, ACT_FILL, ACT_STOP, ACT_UNDER, ACT_OVER
    } act_t;

    typedef enum logic [2:0] {
        K_HALT, K_LOAD, K_LIT, K_STORE, K_ADD, K_MUL
    } kind_t;

    typedef enum logic [2:0] {
        CO_HOLD, CO_PUSH, CO_DROP, CO_MERGE, CO_FILL, CO_SPILL
    } cop_t;

endpackage

// File: rtl/stk_decode.sv
module stk_decode
    import stk_pkg::*;
(
    input  logic [23:0] word,
    output kind_t       kind,
    output logic [15:0] field,
    output logic [1:0]  len,
    output logic [1:0]  need,
    output logic        is_push
);
    always_comb begin
        field = {word[15:8], word[23:16]};
        unique case (word[7:0])
            OPC_LOAD:  kind = K_LOAD;
            OPC_LIT:   kind = K_LIT;
            OPC_STORE: kind = K_STORE;
            OPC_ADD:   kind = K_ADD;
            OPC_MUL:   kind = K_MUL;
            default:   kind = K_HALT;
        endcase
        len     = (kind == K_ADD || kind == K_MUL || kind == K_HALT) ? 2'd1 : 2'd3;
        need    = (kind == K_ADD || kind == K_MUL) ? 2'd2 :
                  (kind == K_STORE) ? 2'd1 : 2'd0;
        is_push = (kind == K_LOAD) || (kind == K_LIT);
    end
endmodule

// File: rtl/stk_alu.sv
module stk_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_mul,
    output logic [W-1:0] y
);
    logic [2*W-1:0] prod;
    always_comb begin
        prod = a * b;
        y    = is_mul ? prod[W-1:0] : a + b;
    end
endmodule

// File: rtl/stk_cache.sv
module stk_cache
    import stk_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  cop_t                    op,
    input  logic [W-1:0]            din,
    output logic [W-1:0]            top,
    output logic [W-1:0]            nxt,
    output logic [W-1:0]            deep,
    output logic [$clog2(N+1)-1:0]  cnt
);
    localparam int CW = $clog2(N+1);

    logic [W-1:0] ent [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic [W-1:0] q, up_v, dn_v;
        if (i == 0) begin : g_first
            assign up_v = din;
        end else begin : g_mid_up
            assign up_v = ent[i-1];
        end
        if (i == N-1) begin : g_last
            assign dn_v = '0;
        end else begin : g_mid_dn
            assign dn_v = ent[i+1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (!clr) begin
                case (op)
                    CO_PUSH:  q <= up_v;
                    CO_DROP:  q <= dn_v;
                    CO_MERGE: q <= (i == 0) ? din : dn_v;
                    CO_FILL:  if (cnt == CW'(i)) q <= din;
                    default:  ;
                endcase
            end
        end
        assign ent[i] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            case (op)
                CO_PUSH, CO_FILL:            cnt <= cnt + 1'b1;
                CO_DROP, CO_MERGE, CO_SPILL: cnt <= cnt - 1'b1;
                default:                     ;
            endcase
        end
    end

    assign top  = ent[0];
    assign nxt  = ent[1];
    assign deep = ent[N-1];

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(N));                                              // R6
    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && op == CO_PUSH) |=> top == $past(din));              // R3
    AST_FILL_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && op == CO_FILL) |-> cnt < CW'(N));                   // R7
endmodule

// File: rtl/stk_core.sv
module stk_core
    import stk_pkg::*;
#(
    parameter int IA_W        = 8,
    parameter int DA_W        = 8,
    parameter int N_REG       = 4,
    parameter int SPILL_DEPTH = 8,
    parameter int SPILL_BASE  = 240,
    parameter int DEP_W       = $clog2(N_REG + SPILL_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [IA_W-1:0]  imem_addr,
    input  logic [23:0]      imem_rdata,
    output logic [DA_W-1:0]  dmem_addr,
    output logic             dmem_re,
    output logic             dmem_we,
    output logic [15:0]      dmem_wdata,
    input  logic [15:0]      dmem_rdata,
    output logic [15:0]      tos_dbg,
    output logic [DEP_W-1:0] depth_dbg,
    output logic             ovf_flag,
    output logic             unf_flag
);
    localparam int CW   = $clog2(N_REG + 1);
    localparam int MC_W = $clog2(SPILL_DEPTH + 1);

    state_t            state_q, state_d;
    act_t              act;
    cop_t              cop;
    kind_t             kind;
    logic [15:0]       field, cdin, top, nxt, deep, alu_y;
    logic [1:0]        len, need;
    logic              is_push, clr;
    logic [CW-1:0]     cnt;
    logic [IA_W-1:0]   pc_q;
    logic [MC_W-1:0]   mc_q;
    logic [DEP_W-1:0]  total;
    logic [DA_W-1:0]   spill_wr;

    stk_decode u_dec (
        .word(imem_rdata), .kind(kind), .field(field),
        .len(len), .need(need), .is_push(is_push)
    );

    stk_alu #(.W(16)) u_alu (
        .a(nxt), .b(top), .is_mul(kind == K_MUL), .y(alu_y)
    );

    stk_cache #(.W(16), .N(N_REG)) u_cache (
        .clk(clk), .rst_n(rst_n), .clr(clr), .op(cop), .din(cdin),
        .top(top), .nxt(nxt), .deep(deep), .cnt(cnt)
    );

    assign clr      = start && (state_q != ST_RUN);
    assign total    = DEP_W'(cnt) + DEP_W'(mc_q);
    assign spill_wr = DA_W'(SPILL_BASE) + DA_W'(mc_q);

    // Per-cycle action while running
    always_comb begin
        if (kind == K_HALT)
            act = ACT_STOP;
        else if (DEP_W'(need) > total)
            act = ACT_UNDER;
        else if (CW'(need) > cnt)
            act = ACT_FILL;
        else if (is_push && cnt == CW'(N_REG))
            act = (mc_q == MC_W'(SPILL_DEPTH)) ? ACT_OVER : ACT_SPILL;
        else
            act = ACT_EXEC;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_HALT: if (start) state_d = ST_RUN;
            ST_RUN: if (act == ACT_STOP || act == ACT_UNDER || act == ACT_OVER)
                        state_d = ST_HALT;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Program counter, spill count and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0; mc_q <= '0; ovf_flag <= 1'b0; unf_flag <= 1'b0;
        end else if (clr) begin
            pc_q <= '0; mc_q <= '0; ovf_flag <= 1'b0; unf_flag <= 1'b0;
        end else if (state_q == ST_RUN) begin
            unique case (act)
                ACT_EXEC:  pc_q <= pc_q + IA_W'(len);
                ACT_SPILL: mc_q <= mc_q + 1'b1;
                ACT_FILL:  mc_q <= mc_q - 1'b1;
                ACT_UNDER: unf_flag <= 1'b1;
                ACT_OVER:  ovf_flag <= 1'b1;
                default:   ;
            endcase
        end
    end

    // Outputs and datapath controls
    always_comb begin
        cop        = CO_HOLD;
        cdin       = field;
        dmem_addr  = field[DA_W-1:0];
        dmem_re    = 1'b0;
        dmem_we    = 1'b0;
        dmem_wdata = top;
        if (state_q == ST_RUN && !clr) begin
            unique case (act)
                ACT_SPILL: begin
                    cop = CO_SPILL; dmem_addr = spill_wr;
                    dmem_we = 1'b1; dmem_wdata = deep;
                end
                ACT_FILL: begin
                    cop = CO_FILL; dmem_addr = spill_wr - 1'b1;
                    dmem_re = 1'b1; cdin = dmem_rdata;
                end
                ACT_EXEC: begin
                    unique case (kind)
                        K_LOAD:       begin cop = CO_PUSH; dmem_re = 1'b1; cdin = dmem_rdata; end
                        K_LIT:        cop = CO_PUSH;
                        K_STORE:      begin cop = CO_DROP; dmem_we = 1'b1; end
                        K_ADD, K_MUL: begin cop = CO_MERGE; cdin = alu_y; end
                        default:      ;
                    endcase
                end
                default: ;
            endcase
        end
        busy      = (state_q == ST_RUN);
        done      = (state_q == ST_HALT);
        imem_addr = pc_q;
        tos_dbg   = (cnt != '0) ? top : 16'h0000;
        depth_dbg = total;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        mc_q <= MC_W'(SPILL_DEPTH));                                       // R9
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_flag && !clr) |=> unf_flag);                                  // R8
    AST_UNDER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && act == ACT_UNDER) |-> !dmem_we);             // R8
    AST_STALL_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && (act == ACT_SPILL || act == ACT_FILL))
            |=> $stable(pc_q));                                            // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> (!dmem_we && !dmem_re));                   // R1
endmodule

// File: tb/stk_core_tb.sv
`timescale 1ns/1ps
module stk_core_tb;
    localparam int IA_W = 8, DA_W = 8, DEP_W = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n, start, busy, done, dmem_re, dmem_we, ovf_flag, unf_flag;
    logic [IA_W-1:0]  imem_addr;
    logic [23:0]      imem_rdata;
    logic [DA_W-1:0]  dmem_addr;
    logic [15:0]      dmem_wdata, dmem_rdata, tos_dbg;
    logic [DEP_W-1:0] depth_dbg;

    logic [7:0]  im [256];
    logic [15:0] dm [256];

    assign imem_rdata = {im[imem_addr + 8'd2], im[imem_addr + 8'd1], im[imem_addr]};
    assign dmem_rdata = dm[dmem_addr];

    stk_core u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_we(dmem_we),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .tos_dbg(tos_dbg), .depth_dbg(depth_dbg),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    int errs = 0, chks = 0, wp = 0, cyc = 0, rds = 0;
    bit finished = 0;

    task automatic chk(input string tag, input int act, input int exp);
        chks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_prog();
        for (int i = 0; i < 256; i++) im[i] = 8'h00;
        wp = 0;
    endtask

    task automatic op1(input logic [7:0] o);
        im[wp] = o; wp++;
    endtask

    task automatic op3(input logic [7:0] o, input logic [15:0] v);
        im[wp] = o; im[wp+1] = v[15:8]; im[wp+2] = v[7:0]; wp += 3;
    endtask

    task automatic run();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0; rds = 0;
        while (!done && cyc < 600) begin
            if (busy) cyc++;
            if (dmem_re) rds++;
            if (dmem_we) dm[dmem_addr] = dmem_wdata;
            @(negedge clk);
        end
        if (!done) chk("R1 run timeout", 0, 1);
    endtask

    function automatic logic [15:0] vval(input int i);
        return 16'h1000 + 16'(i * 37);
    endfunction

    function automatic int extra(input int n);
        return (n > 4) ? n - 4 : 0;
    endfunction

    initial begin
        #3_000_000;
        if (!finished) begin
            errs++; chks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, chks);
            $finish;
        end
    end

    initial begin
        logic [15:0] a, b, e, s;
        logic [31:0] p;
        logic [15:0] av [6];
        logic [15:0] bv [6];
        logic [15:0] pv [6];
        rst_n = 1'b0; start = 1'b0;
        for (int i = 0; i < 256; i++) dm[i] = 16'h0;
        clr_prog();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy after reset", busy, 0);
        chk("R1 done after reset", done, 0);
        chk("R10 depth after reset", depth_dbg, 0);
        chk("R1 flags after reset", {ovf_flag, unf_flag}, 0);

        // R11 / R3 / R5: example expression, several operand pairs
        av = '{16'd3, 16'd0, 16'hFFFF, 16'd1000, 16'd300, 16'd12345};
        bv = '{16'd4, 16'd7, 16'd2, 16'hFFFF, 16'd300, 16'd0};
        for (int k = 0; k < 6; k++) begin
            a = av[k]; b = bv[k];
            dm[8'h10] = a; dm[8'h11] = b; dm[8'h12] = 16'h5A5A;
            clr_prog();
            op3(8'h01, 16'h0010); op3(8'h02, 16'd145); op3(8'h01, 16'h0011);
            op1(8'h10); op1(8'h11); op3(8'h03, 16'h0012); op1(8'h00);
            run();
            s = 16'd145 + b; p = a * s; e = p[15:0];
            chk("R11 result", dm[8'h12], e);
            chk("R11 cycles", cyc, 7);
            chk("R3 data reads", rds, 2);
            chk("R10 depth after store", depth_dbg, 0);
            chk("R1 done after halt", done, 1);
        end

        // R3: literal push makes no data read; R4 store
        clr_prog();
        op3(8'h02, 16'hC0DE); op3(8'h03, 16'h0030); op1(8'h00);
        run();
        chk("R3 literal no read", rds, 0);
        chk("R4 stored literal", dm[8'h30], 16'hC0DE);
        chk("R2 literal cycles", cyc, 3);

        // R6 / R10: push-only depth sweep
        for (int n = 1; n <= 12; n++) begin
            clr_prog();
            for (int i = 1; i <= n; i++) op3(8'h02, vval(i));
            op1(8'h00);
            run();
            chk("R10 depth after pushes", depth_dbg, n);
            chk("R10 top after pushes", tos_dbg, vval(n));
            chk("R6 push cycles", cyc, n + 1 + extra(n));
            if (n == 12)
                for (int k = 0; k < 8; k++)
                    chk("R6 spill slot content", dm[8'hF0 + k], vval(k + 1));
        end

        // R7 / R4: push then drain, every depth
        for (int n = 1; n <= 12; n++) begin
            for (int j = 0; j < 16; j++) dm[8'h40 + j] = 16'hFFFF;
            clr_prog();
            for (int i = 1; i <= n; i++) op3(8'h02, vval(i));
            for (int j = 0; j < n; j++) op3(8'h03, 16'(16'h0040 + j));
            op1(8'h00);
            run();
            for (int j = 0; j < n; j++)
                chk("R7 drained order", dm[8'h40 + j], vval(n - j));
            chk("R7 drain cycles", cyc, 2 * n + 1 + 2 * extra(n));
            chk("R10 depth after drain", depth_dbg, 0);
        end

        // R9: one push past capacity
        dm[8'hF8] = 16'hDEAD;
        clr_prog();
        for (int i = 1; i <= 13; i++) op3(8'h02, vval(i));
        op1(8'h00);
        run();
        chk("R9 overflow flag", ovf_flag, 1);
        chk("R9 underflow stays low", unf_flag, 0);
        chk("R9 depth kept", depth_dbg, 12);
        chk("R9 no write past region", dm[8'hF8], 16'hDEAD);
        chk("R9 cycles", cyc, 21);

        // R8: add with one entry, store after must not happen
        dm[8'h20] = 16'hBEEF;
        clr_prog();
        op3(8'h02, 16'd7); op1(8'h10); op3(8'h03, 16'h0020); op1(8'h00);
        run();
        chk("R8 underflow flag", unf_flag, 1);
        chk("R8 stack unchanged depth", depth_dbg, 1);
        chk("R8 stack unchanged top", tos_dbg, 7);
        chk("R8 no store", dm[8'h20], 16'hBEEF);
        chk("R8 cycles", cyc, 2);
        chk("R8 overflow low", ovf_flag, 0);

        // R8: store on empty stack
        dm[8'h21] = 16'h1234;
        clr_prog();
        op3(8'h03, 16'h0021); op1(8'h00);
        run();
        chk("R8 store-empty flag", unf_flag, 1);
        chk("R8 store-empty no write", dm[8'h21], 16'h1234);

        // R1: a new start clears the sticky flag
        clr_prog();
        op3(8'h02, 16'd5); op1(8'h00);
        run();
        chk("R1 flag cleared on start", unf_flag, 0);
        chk("R1 depth after restart", depth_dbg, 1);

        // R5 / R7: arithmetic chain needing reloads
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 6; i++) pv[i] = 16'(k * 1111 + i * 257 + 3);
            if (k == 3) pv[5] = 16'hFFFF;
            clr_prog();
            for (int i = 0; i < 6; i++) op3(8'h02, pv[i]);
            op1(8'h11); op1(8'h10); op1(8'h11); op1(8'h10); op1(8'h10);
            op3(8'h03, 16'h0050); op1(8'h00);
            run();
            p = pv[4] * pv[5]; e = p[15:0];
            e = pv[3] + e;
            p = pv[2] * e; e = p[15:0];
            e = pv[1] + e;
            e = pv[0] + e;
            chk("R5 chain result", dm[8'h50], e);
            chk("R7 chain cycles", cyc, 17);
            chk("R7 chain reload reads", rds, 2);
        end

        // R2: illegal opcode halts
        clr_prog();
        op3(8'h02, 16'd9); op1(8'h55); op3(8'h02, 16'd3); op1(8'h00);
        run();
        chk("R2 illegal halts", cyc, 2);
        chk("R2 illegal depth", depth_dbg, 1);
        chk("R2 illegal top", tos_dbg, 9);
        chk("R2 illegal flags", {ovf_flag, unf_flag}, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end
endmodule